// File: doc/BRIEF.md
# Multiplexed Bus Target Controller

This block is the responding side of a synchronous shared bus in which one set of wires carries the address in the first cycle of a transfer and data in later cycles. A 3-bit operation field names the command when the master starts a transfer. When the target finishes, it drives the same field with a completion code and raises `finish`. The target claims only transfers whose address lies in its own window. It serves single-word and counted block reads and writes against a small internal memory, and it generates the consecutive word addresses of a block itself.

A read reserves one idle cycle after the address so that the shared wires can change direction. The stall count on `wait_states` is captured when a transfer starts. On a write, that many idle cycles come between the last data word and the completion cycle. On a read, they come between the turnaround cycle and the first data word, and the target marks them with a hold code. Block data moves one word per clock. The target stops driving the shared lines in the cycle after its last word or completion code.

Top module: `mbus_target`

## Requirements
- R1: While reset is asserted, and after it is released, `finish` is low and the target drives neither `op` nor `ad`. A reset in the middle of a transfer abandons that transfer. Memory words reset to zero.
- R2: A start is ignored unless the start-cycle op is a command (READ=1, WRITE=2, RBLK=3, WBLK=4) and address `ad[7:0]` has the window's upper nibble (0x4, covering 0x40..0x4F). An ignored start gives no `finish` and no drive.
- R3: In the cycle where `finish` is high, `op` carries the completion code: OK=1, FAIL=2 or RETRY=3.
- R4: A single READ with zero stall cycles follows this sequence. The address is in cycle 0. Cycle 1 is a turnaround with nothing driven. In cycle 2 the target drives the word on `ad` together with `finish`. The count field is ignored for single reads.
- R5: For a single WRITE, the master drives the data word in cycle 1 and `finish` comes in cycle 2 plus the stall count. On OK the word is stored.
- R6: A stall count of W delays `finish` by W cycles for both reads and writes. During the W read-stall cycles the target drives `op`=HOLD (6) without `finish`.
- R7: For WBLK, the count N is in `ad[15:8]` of the start cycle. The master sends N words in cycles 1..N, each marked with `op`=CONT (5). On OK they are stored at A, A+1, ... in order. `finish` comes in cycle N+1+W.
- R8: For RBLK with count N, the target drives words from A, A+1, ... on N consecutive cycles starting at cycle 2+W. Every word except the last carries CONT. The last word carries the completion code and `finish`.
- R9: FAIL is returned, with nothing stored and no read data, in two cases: a block count of zero, or a burst that runs past the last memory word. A failed read finishes in cycle 2+W.
- R10: A block count above 8 returns RETRY. The write data is absorbed but not stored, and a read finishes in cycle 2+W with no data.
- R11: The target drives neither `op` nor `ad` in the cycle after `finish`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Master marks the address cycle of a transfer |
| wait_states | input | 3 | Stall cycles to insert, captured at start |
| finish | output | 1 | Target marks its completion cycle |
| op | inout | 3 | Command from master; CONT/HOLD markers; completion code from target |
| ad | inout | 16 | Shared address/count and data lines |

## Verification
The assertions assume that the master never raises `start` while the target is still in a transfer. They also assume that it drives the address and command for exactly one cycle and, on writes, exactly as many data words as the effective count. The bench master drives each transfer and then waits through the completion cycle and one more bus-free cycle before it starts the next. It keeps the count and the stall setting stable across a transfer and lets go of the shared lines before the target's turn. Because of this, the protocol properties are only exercised in legal sequences, while the window, count and overrun corners are still reached through the stimulus table.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

   typedef enum logic [2:0] {
      OP_IDLE  = 3'd0,
      OP_READ  = 3'd1,
      OP_WRITE = 3'd2,
      OP_RBLK  = 3'd3,
      OP_WBLK  = 3'd4,
      OP_CONT  = 3'd5,
      OP_HOLD  = 3'd6
   } op_e;

   // completion codes share the op lines, qualified by finish
   localparam logic [2:0] ST_OK    = 3'd1;
   localparam logic [2:0] ST_FAIL  = 3'd2;
   localparam logic [2:0] ST_RETRY = 3'd3;

   typedef enum logic [2:0] {
      S_IDLE,
      S_TURN,
      S_RWAIT,
      S_RDATA,
      S_WDATA,
      S_WWAIT,
      S_STAT
   } seq_e;

endpackage

// File: rtl/mbt_window.sv
module mbt_window
   import mbt_pkg::*;
#(
   parameter int AW        = 8,
   parameter int CW        = 8,
   parameter int LW        = 4,
   parameter int DEPTH     = 16,
   parameter logic [AW-1:0] BASE = 8'h40,
   parameter int MAX_BURST = 8
) (
   input  logic [2:0]    op_in,
   input  logic [AW-1:0] addr,
   input  logic [CW-1:0] cnt,
   output logic          claim,
   output logic          is_read,
   output logic [2:0]    status,
   output logic [CW-1:0] eff_cnt,
   output logic [LW-1:0] lo
);

   localparam logic [CW:0]   DEPTH_V = (CW+1)'(DEPTH);
   localparam logic [CW-1:0] MAXB_V  = CW'(MAX_BURST);

   logic          is_cmd;
   logic          single;
   logic [CW:0]   span;

   always_comb begin
      is_cmd  = (op_in == OP_READ) || (op_in == OP_WRITE) ||
                (op_in == OP_RBLK) || (op_in == OP_WBLK);
      single  = (op_in == OP_READ) || (op_in == OP_WRITE);
      is_read = (op_in == OP_READ) || (op_in == OP_RBLK);
      claim   = is_cmd && (addr[AW-1:LW] == BASE[AW-1:LW]);
      lo      = addr[LW-1:0];
      eff_cnt = single ? CW'(1) : cnt;
      span    = (CW+1)'(lo) + (CW+1)'(eff_cnt);
      if (eff_cnt == '0)
         status = ST_FAIL;
      else if (eff_cnt > MAXB_V)
         status = ST_RETRY;
      else if (span > DEPTH_V)
         status = ST_FAIL;
      else
         status = ST_OK;
   end

endmodule

// File: rtl/mbt_mem.sv
module mbt_mem #(
   parameter int DW    = 16,
   parameter int DEPTH = 16,
   parameter int LW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [LW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] words [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) words[i] <= '0;
      end else if (we) begin
         words[addr] <= wdata;
      end
   end

   assign rdata = words[addr];

endmodule

// File: rtl/mbt_seq.sv
module mbt_seq
   import mbt_pkg::*;
#(
   parameter int CW  = 8,
   parameter int LW  = 4,
   parameter int WSW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [WSW-1:0] wait_in,
   input  logic           claim,
   input  logic           is_read,
   input  logic [2:0]     status,
   input  logic [CW-1:0]  eff_cnt,
   input  logic [LW-1:0]  lo,
   output logic           finish,
   output logic           op_oe,
   output logic [2:0]     op_drv,
   output logic           ad_oe,
   output logic           mem_we,
   output logic [LW-1:0]  mem_addr
);

   seq_e           st;
   logic [LW-1:0]  ptr;
   logic [CW-1:0]  remain;
   logic [WSW-1:0] wcnt;
   logic [WSW-1:0] wq;
   logic [2:0]     stat_q;
   logic           ok;

   assign ok = (stat_q == ST_OK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         ptr    <= '0;
         remain <= '0;
         wcnt   <= '0;
         wq     <= '0;
         stat_q <= ST_OK;
      end else begin
         unique case (st)
            S_IDLE: begin
               if (start && claim) begin
                  ptr    <= lo;
                  remain <= eff_cnt;
                  stat_q <= status;
                  wq     <= wait_in;
                  if (is_read) begin
                     st <= S_TURN;
                  end else if (eff_cnt != '0) begin
                     st <= S_WDATA;
                  end else if (wait_in == '0) begin
                     st <= S_STAT;
                  end else begin
                     st   <= S_WWAIT;
                     wcnt <= wait_in;
                  end
               end
            end
            S_TURN: begin
               if (wq == '0) begin
                  st <= ok ? S_RDATA : S_STAT;
               end else begin
                  st   <= S_RWAIT;
                  wcnt <= wq;
               end
            end
            S_RWAIT: begin
               wcnt <= wcnt - 1'b1;
               if (wcnt == WSW'(1)) st <= ok ? S_RDATA : S_STAT;
            end
            S_RDATA: begin
               ptr    <= ptr + 1'b1;
               remain <= remain - 1'b1;
               if (remain == CW'(1)) st <= S_IDLE;
            end
            S_WDATA: begin
               ptr    <= ptr + 1'b1;
               remain <= remain - 1'b1;
               if (remain == CW'(1)) begin
                  if (wq == '0) begin
                     st <= S_STAT;
                  end else begin
                     st   <= S_WWAIT;
                     wcnt <= wq;
                  end
               end
            end
            S_WWAIT: begin
               wcnt <= wcnt - 1'b1;
               if (wcnt == WSW'(1)) st <= S_STAT;
            end
            S_STAT:  st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      finish   = (st == S_STAT) || ((st == S_RDATA) && (remain == CW'(1)));
      op_oe    = (st == S_RWAIT) || (st == S_RDATA) || (st == S_STAT);
      ad_oe    = (st == S_RDATA);
      mem_we   = (st == S_WDATA) && ok;
      mem_addr = ptr;
      if (st == S_RWAIT)
         op_drv = OP_HOLD;
      else if (finish)
         op_drv = stat_q;
      else
         op_drv = OP_CONT;
   end

   // R11: lines are free in the cycle after the completion cycle
   a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> (!op_oe && !ad_oe));

   // R4: the cycle after a claimed read start is a silent turnaround
   a_r4_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && start && claim && is_read) |=> (!ad_oe && !op_oe && !finish));

   // R2: an unclaimed start leaves the sequencer idle
   a_r2_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && !(start && claim)) |=> (st == S_IDLE));

   // R3: completion cycle carries one of the three codes
   a_r3_code: assert property (@(posedge clk) disable iff (!rst_n)
      finish |-> (op_drv == ST_OK || op_drv == ST_FAIL || op_drv == ST_RETRY));

   // R6: stall counter never sits at zero while stalling
   a_r6_stall_count: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RWAIT || st == S_WWAIT) |-> (wcnt != '0));

   // R8: a non-final read word is followed by the next address at once
   a_r8_stream: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RDATA && remain != CW'(1)) |=> (st == S_RDATA && ptr == $past(ptr) + 1'b1));

endmodule

// File: rtl/mbus_target.sv
module mbus_target #(
   parameter int DW        = 16,
   parameter int AW        = 8,
   parameter int DEPTH     = 16,
   parameter logic [AW-1:0] BASE = 8'h40,
   parameter int MAX_BURST = 8,
   parameter int WSW       = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [WSW-1:0] wait_states,
   output logic           finish,
   inout  wire  [2:0]     op,
   inout  wire  [DW-1:0]  ad
);

   localparam int LW = $clog2(DEPTH);
   localparam int CW = DW - AW;

   initial begin
      assert (DW > AW) else $error("count field needs DW > AW");
      assert (DEPTH == (1 << LW)) else $error("DEPTH must be a power of two");
      assert (LW <= CW && LW < AW) else $error("window too large for field widths");
      assert (MAX_BURST >= 1 && MAX_BURST < (1 << CW)) else $error("MAX_BURST out of range");
      assert (WSW >= 1) else $error("WSW must be at least 1");
   end

   logic          claim;
   logic          is_read;
   logic [2:0]    status;
   logic [CW-1:0] eff_cnt;
   logic [LW-1:0] lo;
   logic          op_oe;
   logic [2:0]    op_drv;
   logic          ad_oe;
   logic          mem_we;
   logic [LW-1:0] mem_addr;
   logic [DW-1:0] rdata;

   mbt_window #(
      .AW(AW), .CW(CW), .LW(LW), .DEPTH(DEPTH), .BASE(BASE), .MAX_BURST(MAX_BURST)
   ) u_window (
      .op_in  (op),
      .addr   (ad[AW-1:0]),
      .cnt    (ad[DW-1:AW]),
      .claim  (claim),
      .is_read(is_read),
      .status (status),
      .eff_cnt(eff_cnt),
      .lo     (lo)
   );

   mbt_seq #(
      .CW(CW), .LW(LW), .WSW(WSW)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .wait_in (wait_states),
      .claim   (claim),
      .is_read (is_read),
      .status  (status),
      .eff_cnt (eff_cnt),
      .lo      (lo),
      .finish  (finish),
      .op_oe   (op_oe),
      .op_drv  (op_drv),
      .ad_oe   (ad_oe),
      .mem_we  (mem_we),
      .mem_addr(mem_addr)
   );

   mbt_mem #(
      .DW(DW), .DEPTH(DEPTH), .LW(LW)
   ) u_mem (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (mem_we),
      .addr (mem_addr),
      .wdata(ad),
      .rdata(rdata)
   );

   assign op = op_oe ? op_drv : 3'bz;
   assign ad = ad_oe ? rdata  : {DW{1'bz}};

endmodule

// File: tb/mbus_target_test.sv
module mbus_target_test;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic        start;
   logic [2:0]  wst;
   wire         finish;
   wire  [2:0]  op;
   wire  [15:0] ad;
   logic        m_op_oe, m_ad_oe;
   logic [2:0]  m_op;
   logic [15:0] m_ad;

   assign op = m_op_oe ? m_op : 3'bz;
   assign ad = m_ad_oe ? m_ad : 16'bz;

   mbus_target uut (
      .clk(clk), .rst_n(rst_n), .start(start), .wait_states(wst),
      .finish(finish), .op(op), .ad(ad)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;
   logic [15:0] mem_ref [16];

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // fields: op[37:35] addr[34:27] count[26:19] wait[18:16] seed[15:0]
   localparam int NV = 21;
   localparam logic [37:0] VEC [NV] = '{
      {3'd2, 8'h40, 8'd1, 3'd0, 16'h1111},
      {3'd1, 8'h40, 8'd0, 3'd0, 16'h0000},
      {3'd4, 8'h44, 8'd4, 3'd1, 16'h2000},
      {3'd3, 8'h44, 8'd4, 3'd0, 16'h0000},
      {3'd3, 8'h45, 8'd2, 3'd2, 16'h0000},
      {3'd2, 8'h4F, 8'd0, 3'd3, 16'h3333},
      {3'd1, 8'h4F, 8'd5, 3'd1, 16'h0000},
      {3'd4, 8'h4E, 8'd3, 3'd0, 16'h7000},
      {3'd3, 8'h4E, 8'd3, 3'd1, 16'h0000},
      {3'd1, 8'h4E, 8'd0, 3'd0, 16'h0000},
      {3'd4, 8'h48, 8'd9, 3'd0, 16'h8000},
      {3'd1, 8'h48, 8'd0, 3'd0, 16'h0000},
      {3'd3, 8'h48, 8'd0, 3'd0, 16'h0000},
      {3'd4, 8'h48, 8'd0, 3'd2, 16'h0000},
      {3'd3, 8'h49, 8'd9, 3'd1, 16'h0000},
      {3'd4, 8'h48, 8'd8, 3'd0, 16'h9000},
      {3'd3, 8'h48, 8'd8, 3'd0, 16'h0000},
      {3'd1, 8'h30, 8'd1, 3'd0, 16'h0000},
      {3'd2, 8'h50, 8'd1, 3'd0, 16'h4444},
      {3'd5, 8'h40, 8'd1, 3'd0, 16'h5555},
      {3'd1, 8'h40, 8'd0, 3'd0, 16'h0000}
   };

   task automatic txn(input logic [2:0] cop, input logic [7:0] a, input logic [7:0] c,
                      input logic [2:0] w, input logic [15:0] seed);
      bit hit    = (a[7:4] == 4'h4) && (cop >= 3'd1) && (cop <= 3'd4);
      bit rd     = (cop == 3'd1) || (cop == 3'd3);
      bit single = (cop == 3'd1) || (cop == 3'd2);
      int eff    = single ? 1 : int'(c);
      int lo     = int'(a[3:0]);
      int wi     = int'(w);
      logic [2:0] est;
      int exp_fin;
      int fin = -1;
      logic [2:0] fop = 3'd0;
      int j = 0;
      string tag;

      if (eff == 0)           est = 3'd2;
      else if (eff > 8)       est = 3'd3;
      else if (lo + eff > 16) est = 3'd2;
      else                    est = 3'd1;
      exp_fin = rd ? ((est == 3'd1) ? 1 + wi + eff : 2 + wi) : eff + 1 + wi;
      if (est == 3'd2)      tag = "R9";
      else if (est == 3'd3) tag = "R10";
      else if (rd)          tag = single ? "R4" : "R8";
      else                  tag = single ? "R5" : "R7";

      @(posedge clk); #1;
      start = 1'b1; m_op = cop; m_ad = {c, a}; m_op_oe = 1'b1; m_ad_oe = 1'b1; wst = w;
      for (int k = 1; k <= 40; k++) begin
         @(posedge clk); #1;
         start = 1'b0;
         if (!rd && k <= eff) begin
            m_op = 3'd5;
            m_ad = seed + 16'(k - 1) * 16'h0101;
         end else begin
            m_op_oe = 1'b0;
            m_ad_oe = 1'b0;
         end
         @(negedge clk);
         if (hit && rd && est == 3'd1 && k >= 2 + wi && k <= 1 + wi + eff) begin
            check(ad == mem_ref[lo + j], tag, 32'(ad), 32'(mem_ref[lo + j]));
            if (k < 1 + wi + eff) check(op == 3'd5 && !finish, "R8", 32'(op), 32'd5);
            j++;
         end
         if (hit && rd && k >= 2 && k < 2 + wi)
            check(op == 3'd6 && !finish, "R6", 32'(op), 32'd6);
         if (finish) begin
            fin = k;
            fop = op;
            break;
         end
         if (!hit && k >= 12) break;
      end

      if (!hit) begin
         check(fin == -1, "R2", 32'(fin), 32'hffffffff);
      end else begin
         check(fin == exp_fin, tag, 32'(fin), 32'(exp_fin));
         check(fop == est, "R3", 32'(fop), 32'(est));
         if (wi > 0) check(fin == exp_fin, "R6", 32'(fin), 32'(exp_fin));
         if (!rd && est == 3'd1)
            for (int q = 0; q < eff; q++) mem_ref[lo + q] = seed + 16'(q) * 16'h0101;
         @(posedge clk); #1;
         m_ad_oe = 1'b1; m_ad = 16'h5A5A; m_op_oe = 1'b1; m_op = 3'd0;
         @(negedge clk);
         check(!finish && ad == 16'h5A5A && op == 3'd0, "R11", 32'(ad), 32'h5A5A);
      end
      @(posedge clk); #1;
      m_op_oe = 1'b0; m_ad_oe = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) mem_ref[i] = 16'h0000;
      rst_n = 1'b0; start = 1'b0; wst = 3'd0;
      m_op_oe = 1'b0; m_ad_oe = 1'b0; m_op = 3'd0; m_ad = 16'h0000;
      repeat (3) @(negedge clk);
      check(finish == 1'b0, "R1", 32'(finish), 32'd0);
      @(posedge clk); #1; rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1: bus free after reset - master value passes unchanged
      m_ad_oe = 1'b1; m_ad = 16'hC3C3; m_op_oe = 1'b1; m_op = 3'd0;
      #1;
      check(!finish && ad == 16'hC3C3 && op == 3'd0, "R1", 32'(ad), 32'hC3C3);
      @(posedge clk); #1; m_ad_oe = 1'b0; m_op_oe = 1'b0;

      for (int v = 0; v < NV; v++)
         txn(VEC[v][37:35], VEC[v][34:27], VEC[v][26:19], VEC[v][18:16], VEC[v][15:0]);

      // R1: reset in the middle of a stalled block read abandons it
      @(posedge clk); #1;
      start = 1'b1; m_op = 3'd3; m_ad = {8'd4, 8'h44}; m_op_oe = 1'b1; m_ad_oe = 1'b1; wst = 3'd5;
      @(posedge clk); #1;
      start = 1'b0; m_op_oe = 1'b0; m_ad_oe = 1'b0;
      repeat (2) @(posedge clk);
      #1; rst_n = 1'b0;
      @(negedge clk);
      m_ad_oe = 1'b1; m_ad = 16'h0F0F; m_op_oe = 1'b1; m_op = 3'd0;
      #1;
      check(!finish && ad == 16'h0F0F && op == 3'd0, "R1", 32'(ad), 32'h0F0F);
      @(posedge clk); #1; rst_n = 1'b1; m_ad_oe = 1'b0; m_op_oe = 1'b0;
      for (int i = 0; i < 16; i++) mem_ref[i] = 16'h0000;
      repeat (6) @(negedge clk);
      check(finish == 1'b0, "R1", 32'(finish), 32'd0);
      // R1: memory returns to zero after reset
      txn(3'd1, 8'h44, 8'd0, 3'd0, 16'h0000);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule